// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block sequences conversions for a multi-channel analog-to-digital converter. Software writes a configuration word: a 2-bit mode, a channel number and a start bit. The sequencer then drives a conversion engine one channel at a time. Each conversion takes a fixed number of clock cycles. The engine is modelled here as a counter that reports completion after `CONV_CYCLES` cycles.

Four modes are supported. Fixed-channel single converts one channel once. Fixed-channel continuous converts one channel over and over. Auto-scan single walks once from the programmed channel down to channel 0. Auto-scan continuous repeats that walk.

Configuration writes made while the sequencer is busy are held and applied only at defined boundaries. A mode change is applied after the current conversion. A new channel or start value is applied after the current conversion in fixed-channel modes, and only after channel 0 in scan modes. Every finished conversion raises a one-cycle strobe tagged with the channel just converted.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After synchronous reset, `busy` and `resValid` are 0.
- R2: While idle, a write with `cfgStart`=1 makes `busy` 1 from the next cycle. Every conversion then lasts exactly `CONV_CYCLES` cycles, and consecutive conversions follow each other with no gap.
- R3: Mode 00 (fixed single) converts the programmed channel once. `busy` then returns to 0 and the start bit is cleared.
- R4: Mode 01 (fixed continuous) converts the same channel back to back. A write that clears the start bit lets the current conversion finish, and then the sequencer goes idle.
- R5: Mode 10 (scan single) converts channels in descending order, from the programmed channel to 0, and then goes idle with the start bit cleared.
- R6: Mode 11 (scan continuous) restarts at the programmed channel after channel 0, until the start bit is cleared.
- R7: While idle, a write with `cfgStart`=0 starts nothing, whatever the mode and whatever channel was converted last.
- R8: A channel write made during a fixed-channel conversion takes effect from the next conversion.
- R9: Channel and start writes made during a scan take effect only after channel 0 has been converted.
- R10: If the mode is switched to a scan mode during a fixed-channel conversion of channel n (start still 1), channels n-1 down to 0 follow.
- R11: Each completed conversion gives exactly one cycle of `resValid`, with `resChan` equal to the channel converted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgWe | input | 1 | Configuration write strobe |
| cfgMode | input | 2 | Mode: 00 fixed single, 01 fixed continuous, 10 scan single, 11 scan continuous |
| cfgChan | input | CH_W | Channel number (scan start channel in scan modes) |
| cfgStart | input | 1 | Start bit |
| busy | output | 1 | 1 while a conversion or sequence is in progress |
| resValid | output | 1 | One-cycle strobe when a conversion completes |
| resChan | output | CH_W | Channel of the completed conversion |

## Verification
The bench targets the idle write of a scan mode without the start bit. A design that fired on the mode field alone would begin an unwanted scan from the last channel it converted.

It also switches a fixed-channel conversion to scan mode part way through. A wrong design would restart at the programmed channel instead of continuing downward from n-1.

It writes a new channel during a fixed conversion and during a scan, and clears the start bit in the middle of a scan. Applying any of these too early would cut a scan short, or show up as the wrong channel tag before the boundary.

Finally, it compares every cycle against a behavioural model. This catches a gap between back-to-back conversions and a strobe that lasts more than one cycle.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    MODE_FIX_ONE  = 2'b00,
    MODE_FIX_RUN  = 2'b01,
    MODE_SCAN_ONE = 2'b10,
    MODE_SCAN_RUN = 2'b11
  } seqMode_t;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_CONV = 1'b1
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCfg;   // start from idle with the written configuration
    logic stepDown;  // continue scan with next lower channel
    logic reload;    // new conversion/sequence from pending channel
    logic clrStart;  // single job finished: clear start bit
    logic capture;   // publish result of the finished conversion
  } seqStrobes_t;

endpackage

// File: rtl/adc_conv_stub.sv
module adc_conv_stub #(
  parameter int CONV_CYCLES = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic kick,
  output logic convDone
);
  localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CONV_CYCLES - 1);

  logic [CNT_W-1:0] cnt;
  logic             running;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (kick) begin
      cnt     <= CNT_LOAD;
      running <= 1'b1;
    end else if (running) begin
      if (cnt == '0) running <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  assign convDone = running && (cnt == '0);

  AST_NO_KICK_MIDWAY: assert property (@(posedge clk) disable iff (rst)
    kick |-> (!running || convDone)) else $error("kick during conversion"); // R2

endmodule

// File: rtl/adc_seq_control.sv
module adc_seq_control
  import adc_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cfgWe,
  input  logic        cfgStart,
  input  logic        convDone,
  input  logic [1:0]  actMode,
  input  logic [1:0]  pendMode,
  input  logic        pendStart,
  input  logic        chanZero,
  output seqStrobes_t strobes,
  output logic        busy
);
  seqState_t state, stateNxt;

  always_comb begin
    strobes  = '0;
    stateNxt = state;
    unique case (state)
      SEQ_IDLE: begin
        if (cfgWe && cfgStart) begin
          strobes.loadCfg = 1'b1;
          stateNxt        = SEQ_CONV;
        end
      end
      SEQ_CONV: begin
        if (convDone) begin
          strobes.capture = 1'b1;
          if (pendMode[1] && !chanZero && (actMode[1] || pendStart)) begin
            strobes.stepDown = 1'b1;
          end else if (!pendStart) begin
            stateNxt = SEQ_IDLE;
          end else if (!pendMode[0] && (actMode == pendMode)) begin
            strobes.clrStart = 1'b1;
            stateNxt         = SEQ_IDLE;
          end else begin
            strobes.reload = 1'b1;
          end
        end
      end
      default: stateNxt = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= SEQ_IDLE;
    else     state <= stateNxt;
  end

  assign busy = (state == SEQ_CONV);

  AST_IDLE_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
    (!busy && !(cfgWe && cfgStart)) |=> !busy) else $error("start without bit"); // R7
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.loadCfg, strobes.stepDown, strobes.reload})) else $error("multiple actions"); // R2
  AST_STEP_NOT_ZERO: assert property (@(posedge clk) disable iff (rst)
    strobes.stepDown |-> !chanZero) else $error("step below zero"); // R5
  AST_SINGLE_ENDS: assert property (@(posedge clk) disable iff (rst)
    strobes.clrStart |=> !busy) else $error("single job did not end"); // R3

endmodule

// File: rtl/adc_seq_datapath.sv
module adc_seq_datapath
  import adc_seq_pkg::*;
#(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfgWe,
  input  logic [1:0]      cfgMode,
  input  logic [CH_W-1:0] cfgChan,
  input  logic            cfgStart,
  input  seqStrobes_t     strobes,
  output logic [1:0]      actMode,
  output logic [1:0]      pendMode,
  output logic            pendStart,
  output logic            chanZero,
  output logic [CH_W-1:0] curChan,
  output logic            resValid,
  output logic [CH_W-1:0] resChan
);
  logic [CH_W-1:0] pendChan;

  // software-visible pending configuration
  always_ff @(posedge clk) begin
    if (rst) begin
      pendMode  <= MODE_FIX_ONE;
      pendChan  <= '0;
      pendStart <= 1'b0;
    end else if (cfgWe) begin
      pendMode  <= cfgMode;
      pendChan  <= cfgChan;
      pendStart <= cfgStart;
    end else if (strobes.clrStart) begin
      pendStart <= 1'b0;
    end
  end

  // active mode and channel under conversion
  always_ff @(posedge clk) begin
    if (rst) begin
      actMode <= MODE_FIX_ONE;
      curChan <= '0;
    end else if (strobes.loadCfg) begin
      actMode <= cfgMode;
      curChan <= cfgChan;
    end else if (strobes.stepDown) begin
      actMode <= pendMode;
      curChan <= curChan - 1'b1;
    end else if (strobes.reload) begin
      actMode <= pendMode;
      curChan <= pendChan;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resValid <= 1'b0;
      resChan  <= '0;
    end else begin
      resValid <= strobes.capture;
      if (strobes.capture) resChan <= curChan;
    end
  end

  assign chanZero = (curChan == '0);

  AST_TAG_IS_CHANNEL: assert property (@(posedge clk) disable iff (rst)
    strobes.capture |=> (resValid && resChan == $past(curChan))) else $error("bad tag"); // R11

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int CONV_CYCLES = 6,
  localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfgWe,
  input  logic [1:0]      cfgMode,
  input  logic [CH_W-1:0] cfgChan,
  input  logic            cfgStart,
  output logic            busy,
  output logic            resValid,
  output logic [CH_W-1:0] resChan
);
  seqStrobes_t     strobes;
  logic            convDone;
  logic [1:0]      actMode;
  logic [1:0]      pendMode;
  logic            pendStart;
  logic            chanZero;
  logic [CH_W-1:0] curChan;
  logic            kick;

  assign kick = strobes.loadCfg | strobes.stepDown | strobes.reload;

  adc_seq_control u_ctrl (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgStart(cfgStart),
    .convDone(convDone), .actMode(actMode), .pendMode(pendMode),
    .pendStart(pendStart), .chanZero(chanZero),
    .strobes(strobes), .busy(busy)
  );

  adc_seq_datapath #(.CH_W(CH_W)) u_dp (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgMode(cfgMode),
    .cfgChan(cfgChan), .cfgStart(cfgStart), .strobes(strobes),
    .actMode(actMode), .pendMode(pendMode), .pendStart(pendStart),
    .chanZero(chanZero), .curChan(curChan),
    .resValid(resValid), .resChan(resChan)
  );

  adc_conv_stub #(.CONV_CYCLES(CONV_CYCLES)) u_conv (
    .clk(clk), .rst(rst), .kick(kick), .convDone(convDone)
  );

  AST_CHAN_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && !convDone) |=> $stable(curChan)) else $error("channel changed mid conversion"); // R8
  AST_VALID_FROM_BUSY: assert property (@(posedge clk) disable iff (rst)
    resValid |-> $past(busy)) else $error("result while idle"); // R11

endmodule

// File: tb/adc_seq_ctrl_tb_top.sv
module adc_seq_ctrl_tb_top;
  localparam int NUM_CH = 8;
  localparam int CONV_CYCLES = 6;
  localparam int CH_W = 3;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            cfgWe = 1'b0;
  logic [1:0]      cfgMode = 2'b00;
  logic [CH_W-1:0] cfgChan = '0;
  logic            cfgStart = 1'b0;
  logic            busy, resValid;
  logic [CH_W-1:0] resChan;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string curReq = "R1";
  int seen[$];

  always #4 clk = ~clk; // 125 MHz

  adc_seq_ctrl #(.NUM_CH(NUM_CH), .CONV_CYCLES(CONV_CYCLES)) dut_i (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgMode(cfgMode),
    .cfgChan(cfgChan), .cfgStart(cfgStart),
    .busy(busy), .resValid(resValid), .resChan(resChan)
  );

  // behavioural reference model, updated at each rising edge
  bit mBusy, mValid;
  int mTimer, mChan, mAct, mRes;
  int pMode, pChan;
  bit pStart;

  always @(posedge clk) begin
    bit wasBusy, clr;
    if (rst) begin
      mBusy = 0; mValid = 0; mTimer = 0; mChan = 0; mAct = 0; mRes = 0;
      pMode = 0; pChan = 0; pStart = 0;
    end else begin
      wasBusy = mBusy; clr = 0; mValid = 0;
      if (mBusy) begin
        if (mTimer == 0) begin
          mValid = 1; mRes = mChan;
          if (pMode >= 2 && mChan > 0 && (mAct >= 2 || pStart)) begin
            mChan = mChan - 1; mAct = pMode; mTimer = CONV_CYCLES - 1;
          end else if (!pStart) begin
            mBusy = 0;
          end else if ((pMode % 2) == 0 && mAct == pMode) begin
            mBusy = 0; clr = 1;
          end else begin
            mChan = pChan; mAct = pMode; mTimer = CONV_CYCLES - 1;
          end
        end else begin
          mTimer = mTimer - 1;
        end
      end
      if (cfgWe) begin
        pMode = int'(cfgMode); pChan = int'(cfgChan); pStart = cfgStart;
      end else if (clr) begin
        pStart = 0;
      end
      if (!wasBusy && cfgWe && cfgStart) begin
        mBusy = 1; mChan = int'(cfgChan); mAct = int'(cfgMode); mTimer = CONV_CYCLES - 1;
      end
    end
  end

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      checks++;
      if (busy !== mBusy) begin
        errors++; $display("FAIL %s busy act=%0b exp=%0b", curReq, busy, mBusy);
      end
      checks++;
      if (resValid !== mValid) begin
        errors++; $display("FAIL %s resValid act=%0b exp=%0b", curReq, resValid, mValid);
      end
      if (mValid) begin
        checks++;
        if (int'(resChan) != mRes) begin
          errors++; $display("FAIL %s resChan act=%0d exp=%0d", curReq, resChan, mRes);
        end
      end
      if (resValid === 1'b1) seen.push_back(int'(resChan));
    end
  end

  task automatic cfgWrite(input logic [1:0] m, input int ch, input logic st);
    @(negedge clk);
    cfgWe = 1'b1; cfgMode = m; cfgChan = CH_W'(ch); cfgStart = st;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
    waitCycles(3);
  endtask

  task automatic checkList(input string req, input int exp[$]);
    checks++;
    if (seen.size() != exp.size()) begin
      errors++;
      $display("FAIL %s result count act=%0d exp=%0d", req, seen.size(), exp.size());
    end else begin
      foreach (exp[i]) begin
        if (seen[i] != exp[i]) begin
          errors++;
          $display("FAIL %s channel #%0d act=%0d exp=%0d", req, i, seen[i], exp[i]);
          break;
        end
      end
    end
    seen.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    checks++;
    if (busy !== 1'b0 || resValid !== 1'b0) begin
      errors++; $display("FAIL R1 reset busy/valid act=%0b%0b exp=00", busy, resValid);
    end
    rst = 1'b0;
    waitCycles(2);

    // R2 / R3: fixed single on channel 5
    curReq = "R3";
    cfgWrite(2'b00, 5, 1'b1);
    waitIdle();
    checkList("R3", '{5});

    // R7: mode-only writes while idle start nothing
    curReq = "R7";
    cfgWrite(2'b10, 5, 1'b0);
    waitCycles(10);
    cfgWrite(2'b11, 3, 1'b0);
    waitCycles(20);
    checks++;
    if (busy !== 1'b0) begin
      errors++; $display("FAIL R7 busy act=%0b exp=0", busy);
    end
    checkList("R7", '{});

    // R4: fixed continuous on channel 2, then clear start
    curReq = "R4";
    cfgWrite(2'b01, 2, 1'b1);
    waitCycles(19);
    cfgWrite(2'b01, 2, 1'b0);
    waitIdle();
    checkList("R4", '{2, 2, 2, 2});

    // R8: channel change during a fixed conversion
    curReq = "R8";
    cfgWrite(2'b01, 1, 1'b1);
    waitCycles(1);
    cfgWrite(2'b01, 6, 1'b1);
    waitCycles(10);
    cfgWrite(2'b01, 6, 1'b0);
    waitIdle();
    checkList("R8", '{1, 6, 6});

    // R5: scan single from channel 3
    curReq = "R5";
    cfgWrite(2'b10, 3, 1'b1);
    waitIdle();
    checkList("R5", '{3, 2, 1, 0});

    // R9: start cleared and channel changed mid-scan; the scan completes anyway
    curReq = "R9";
    cfgWrite(2'b11, 4, 1'b1);
    waitCycles(1);
    cfgWrite(2'b11, 2, 1'b0);
    waitIdle();
    checkList("R9", '{4, 3, 2, 1, 0});

    // R6: scan continuous wraps back to the programmed channel
    curReq = "R6";
    cfgWrite(2'b11, 1, 1'b1);
    waitCycles(25);
    cfgWrite(2'b11, 1, 1'b0);
    waitIdle();
    checks++;
    if (seen.size() < 4 || seen[0] != 1 || seen[1] != 0 || seen[2] != 1 || seen[3] != 0) begin
      errors++;
      $display("FAIL R6 wrap count act=%0d exp>=4 first=%0d exp=1", seen.size(),
               (seen.size() > 0) ? seen[0] : -1);
    end
    seen.delete();

    // R10: fixed continuous switched to scan mid conversion
    curReq = "R10";
    cfgWrite(2'b01, 5, 1'b1);
    waitCycles(1);
    cfgWrite(2'b10, 5, 1'b1);
    waitIdle();
    checkList("R10", '{5, 4, 3, 2, 1, 0});

    // R11: strobe spacing is covered by every-cycle comparison; final quiet check
    curReq = "R11";
    waitCycles(10);
    checkList("R11", '{});

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog %s act=running exp=done", curReq);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule